// File: doc/BRIEF.md
# Sustain-Ramp Envelope Controller

This block drives the envelope registers of one voice of a sound chip so that decay and release come from lowering the chip's sustain register step by step. The chip's own decay and release fields stay at zero. A note-on first drops the gate for a short fixed gap and writes full sustain while the gate is low. It then raises the gate, waits a programmable attack time, and steps sustain down toward a target level. A note-off steps sustain down to zero while the gate stays high. The gate is only cleared again at the next retrigger.

The ramp has a rate and a curve. In the linear curve every step takes the same number of clock cycles. In the stretched curve each step interval is twice the previous one, saturating at the widest interval the timer holds. A system instantiates one controller per voice. Every register value on the outputs comes with a one-cycle write strobe, so the chip's register file can be updated directly.

Top module: `sus_ramp_env`

## Requirements
- R1: While reset is high and in the first cycle after it, gate is 0, sustain is 15 and every write strobe is 0.
- R2: A note-on outside the gap gives, in the next cycle: gate 0, sustain 15, decay nibble 0, release nibble 0, attack nibble equal to the attack input sampled with the note-on, and the gate, sustain, attack, decay and release strobes all high for exactly that one cycle.
- R3: After an accepted note-on the gate stays low for exactly GAP_LEN (4) cycles. It then rises with a gate strobe.
- R4: A note-on that arrives during the gap neither restarts nor extends it.
- R5: After the gate rises, sustain holds at 15 for W = max(attack_wait,1) cycles before the first step can occur.
- R6: With curve 0, sustain falls by exactly one every B = max(ramp_rate,1) cycles until it equals the target, then holds. A target of 15 gives no step.
- R7: With curve 1 the first interval is B and each later interval is twice the one before it, saturating at 4095 cycles.
- R8: A note-off during the decay or hold phase starts release. Sustain falls by one per interval, with the interval restarted at B, until it reaches 0. The gate stays high throughout.
- R9: A note-off during the gap or the attack wait is held. Release then starts from 15 at the end of the attack wait, with no decay toward the target.
- R10: Sustain never increases while the gate stays high. A target raised during hold leaves sustain unchanged.
- R11: The sustain strobe is high in each cycle in which a new sustain value is presented, and sustain never changes without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| note_on | input | 1 | One-cycle note-on event |
| note_off | input | 1 | One-cycle note-off event |
| atk_rate | input | 4 | Attack nibble written to the chip at note-on |
| sus_target | input | 4 | Sustain level that the decay stops at |
| ramp_rate | input | RW (8) | Base step interval in cycles (0 acts as 1) |
| ramp_curve | input | 1 | 0 linear, 1 doubling interval |
| attack_wait | input | AW (16) | Attack wait in cycles (0 acts as 1) |
| gate | output | 1 | Gate bit for the chip |
| gate_we | output | 1 | Gate write strobe |
| sus_val | output | 4 | Sustain nibble |
| sus_we | output | 1 | Sustain write strobe |
| atk_nib | output | 4 | Attack nibble |
| atk_we | output | 1 | Attack write strobe |
| dcy_nib | output | 4 | Decay nibble, always 0 |
| dcy_we | output | 1 | Decay write strobe |
| rel_nib | output | 4 | Release nibble, always 0 |
| rel_we | output | 1 | Release write strobe |

## Verification
Every output is registered, so each result appears in the cycle after the edge that samples the note event. The gate falls one cycle after the edge, rises GAP_LEN cycles after that, and the first sustain step lands W plus the current interval cycles after the gate rises. The bench drives inputs and samples outputs on the falling clock edge and counts cycles from the edge that sampled the event. It compares sustain and gate every cycle against a step schedule it builds from the rate, curve, wait and target, so a step that comes one cycle early or late is caught. Release and pending-release checks count from the edge that sampled the note-off, or from the end of the attack wait.

// File: rtl/srd_pkg.sv
package srd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_ATK,
    ST_DCY,
    ST_HOLD,
    ST_REL
  } srd_state_e;

  localparam logic [3:0] SUS_MAX = 4'hF;
endpackage

// File: rtl/srd_countdown.sv
module srd_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/srd_interval.sv
module srd_interval #(
  parameter int RW = 8,
  parameter int IW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          advance,
  input  logic          curve,
  input  logic [RW-1:0] rate,
  output logic [IW-1:0] ivl_next
);
  localparam logic [IW-1:0] IVL_MAX  = '1;
  localparam logic [IW-1:0] IVL_HALF = IW'(1) << (IW - 1);

  logic [IW-1:0] cur;
  logic [IW-1:0] base;
  logic [IW-1:0] dbl;

  always_comb begin
    base     = (rate == '0) ? IW'(1) : IW'(rate);
    dbl      = (cur >= IVL_HALF) ? IVL_MAX : (cur << 1);
    ivl_next = start ? base : (curve ? dbl : cur);
  end

  always_ff @(posedge clk) begin
    if (rst)                  cur <= IW'(1);
    else if (start || advance) cur <= ivl_next;
  end
endmodule

// File: rtl/sus_ramp_env.sv
module sus_ramp_env
  import srd_pkg::*;
#(
  parameter int RW      = 8,
  parameter int AW      = 16,
  parameter int GAP_LEN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          note_on,
  input  logic          note_off,
  input  logic [3:0]    atk_rate,
  input  logic [3:0]    sus_target,
  input  logic [RW-1:0] ramp_rate,
  input  logic          ramp_curve,
  input  logic [AW-1:0] attack_wait,
  output logic          gate,
  output logic          gate_we,
  output logic [3:0]    sus_val,
  output logic          sus_we,
  output logic [3:0]    atk_nib,
  output logic          atk_we,
  output logic [3:0]    dcy_nib,
  output logic          dcy_we,
  output logic [3:0]    rel_nib,
  output logic          rel_we
);
  localparam int IW = RW + 4;
  localparam int GW = $clog2(GAP_LEN + 1);
  localparam int PW = (AW > GW) ? AW : GW;

  srd_state_e    st;
  logic          rel_pend;
  logic          ev_on, gap_done, atk_done, go_rel, want_rel;
  logic          ph_load, ph_zero;
  logic [PW-1:0] ph_val;
  logic          stp_start, stp_adv, stp_zero;
  logic [IW-1:0] ivl_next;

  always_comb begin
    ev_on     = note_on && (st != ST_GAP);
    gap_done  = (st == ST_GAP) && ph_zero;
    atk_done  = !note_on && (st == ST_ATK) && ph_zero;
    want_rel  = rel_pend || note_off;
    go_rel    = !note_on && note_off && ((st == ST_DCY) || (st == ST_HOLD));
    ph_load   = ev_on || gap_done;
    ph_val    = ev_on ? PW'(GAP_LEN - 1)
              : ((attack_wait == '0) ? '0 : PW'(attack_wait - AW'(1)));
    stp_start = (atk_done && (want_rel || (sus_target < SUS_MAX))) || go_rel;
    stp_adv   = !note_on && stp_zero && ((st == ST_DCY) || (st == ST_REL)) && !go_rel;
  end

  srd_countdown #(.W(PW)) u_phase (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  srd_interval #(.RW(RW), .IW(IW)) u_ivl (
    .clk(clk), .rst(rst), .start(stp_start), .advance(stp_adv),
    .curve(ramp_curve), .rate(ramp_rate), .ivl_next(ivl_next)
  );

  srd_countdown #(.W(IW)) u_step (
    .clk(clk), .rst(rst), .load(stp_start || stp_adv),
    .load_val(ivl_next - IW'(1)), .zero(stp_zero)
  );

  assign dcy_nib = 4'd0;
  assign rel_nib = 4'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      rel_pend <= 1'b0;
      gate     <= 1'b0;
      gate_we  <= 1'b0;
      sus_val  <= SUS_MAX;
      sus_we   <= 1'b0;
      atk_nib  <= 4'd0;
      atk_we   <= 1'b0;
      dcy_we   <= 1'b0;
      rel_we   <= 1'b0;
    end else begin
      gate_we <= 1'b0;
      sus_we  <= 1'b0;
      atk_we  <= 1'b0;
      dcy_we  <= 1'b0;
      rel_we  <= 1'b0;
      if (ev_on) begin
        st       <= ST_GAP;
        rel_pend <= 1'b0;
        gate     <= 1'b0;
        gate_we  <= 1'b1;
        sus_val  <= SUS_MAX;
        sus_we   <= 1'b1;
        atk_nib  <= atk_rate;
        atk_we   <= 1'b1;
        dcy_we   <= 1'b1;
        rel_we   <= 1'b1;
      end else begin
        case (st)
          ST_GAP: begin
            if (note_on)       rel_pend <= 1'b0;
            else if (note_off) rel_pend <= 1'b1;
            if (gap_done) begin
              st      <= ST_ATK;
              gate    <= 1'b1;
              gate_we <= 1'b1;
            end
          end
          ST_ATK: begin
            if (note_off) rel_pend <= 1'b1;
            if (atk_done) begin
              rel_pend <= 1'b0;
              if (want_rel)                   st <= ST_REL;
              else if (sus_target < SUS_MAX)  st <= ST_DCY;
              else                            st <= ST_HOLD;
            end
          end
          ST_DCY: begin
            if (go_rel) begin
              st <= ST_REL;
            end else if (stp_zero) begin
              if (sus_val > sus_target) begin
                sus_val <= sus_val - 4'd1;
                sus_we  <= 1'b1;
                if ((sus_val - 4'd1) <= sus_target) st <= ST_HOLD;
              end else begin
                st <= ST_HOLD;
              end
            end
          end
          ST_HOLD: begin
            if (go_rel) st <= (sus_val == 4'd0) ? ST_IDLE : ST_REL;
          end
          ST_REL: begin
            if (stp_zero) begin
              sus_val <= sus_val - 4'd1;
              sus_we  <= 1'b1;
              if (sus_val == 4'd1) st <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/srd_checker.sv
module srd_checker #(
  parameter int GAP_LEN = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       gate,
  input logic       gate_we,
  input logic [3:0] sus_val,
  input logic       sus_we
);
  localparam int CW = $clog2(GAP_LEN + 2);
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst)                          low_cnt <= '0;
    else if (gate)                    low_cnt <= '0;
    else if (low_cnt < CW'(GAP_LEN))  low_cnt <= low_cnt + CW'(1);
  end

  p_gap_len_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(gate) |-> (low_cnt >= CW'(GAP_LEN)));

  p_gate_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    (gate != $past(gate)) |-> gate_we);

  p_no_rise_r10: assert property (@(posedge clk) disable iff (rst)
    (gate && $past(gate)) |-> (sus_val <= $past(sus_val)));

  p_unit_step_r6: assert property (@(posedge clk) disable iff (rst)
    (gate && $past(gate) && (sus_val != $past(sus_val)))
      |-> (sus_val == $past(sus_val) - 4'd1));

  p_sus_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    !sus_we |-> $stable(sus_val));
endmodule

bind sus_ramp_env srd_checker #(.GAP_LEN(GAP_LEN)) u_chk (
  .clk(clk), .rst(rst), .gate(gate), .gate_we(gate_we),
  .sus_val(sus_val), .sus_we(sus_we)
);

// File: tb/tb_sus_ramp_env.sv
module tb_sus_ramp_env;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic note_on = 1'b0, note_off = 1'b0;
  logic [3:0] atk_rate = 4'd0, sus_target = 4'd0;
  logic [7:0] ramp_rate = 8'd1;
  logic ramp_curve = 1'b0;
  logic [15:0] attack_wait = 16'd1;
  logic gate, gate_we, sus_we, atk_we, dcy_we, rel_we;
  logic [3:0] sus_val, atk_nib, dcy_nib, rel_nib;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sus_ramp_env dut (
    .clk(clk), .rst(rst), .note_on(note_on), .note_off(note_off),
    .atk_rate(atk_rate), .sus_target(sus_target), .ramp_rate(ramp_rate),
    .ramp_curve(ramp_curve), .attack_wait(attack_wait),
    .gate(gate), .gate_we(gate_we), .sus_val(sus_val), .sus_we(sus_we),
    .atk_nib(atk_nib), .atk_we(atk_we), .dcy_nib(dcy_nib), .dcy_we(dcy_we),
    .rel_nib(rel_nib), .rel_we(rel_we)
  );

  // {target, rate, curve, wait}
  localparam logic [31:0] VEC [0:4] = '{
    {8'd8,  8'd3, 8'd0, 8'd5},
    {8'd12, 8'd2, 8'd1, 8'd3},
    {8'd0,  8'd1, 8'd0, 8'd2},
    {8'd15, 8'd4, 8'd0, 8'd1},
    {8'd10, 8'd0, 8'd0, 8'd0}
  };

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_sus(int n, int tgt, int rate, int curve, int w);
    int weff = (w == 0) ? 1 : w;
    int iv   = (rate == 0) ? 1 : rate;
    int t    = n - (4 + weff);
    int s    = 15;
    int acc  = 0;
    if (t < 0) return 15;
    while (s > tgt) begin
      acc += iv;
      if (t >= acc) s--;
      else break;
      iv = (curve != 0) ? ((iv * 2 > 4095) ? 4095 : iv * 2) : iv;
    end
    return s;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  // drive a note-on; returns after the sampling edge (cycle n = 0)
  task automatic fire_on(int tgt, int rate, int curve, int w, int atk);
    sus_target = 4'(tgt); ramp_rate = 8'(rate); ramp_curve = curve[0];
    attack_wait = 16'(w); atk_rate = 4'(atk);
    note_on = 1'b1;
    tick();
    note_on = 1'b0;
  endtask

  task automatic fire_off();
    note_off = 1'b1;
    tick();
    note_off = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    check("R1 gate in reset", int'(gate), 0);
    check("R1 sus in reset", int'(sus_val), 15);
    rst = 1'b0;
    tick();
    check("R1 gate after reset", int'(gate), 0);
    check("R1 sus after reset", int'(sus_val), 15);
    check("R1 strobes after reset",
          int'({gate_we, sus_we, atk_we, dcy_we, rel_we}), 0);

    // table walk: R3 R5 R6 R7 cycle by cycle
    foreach (VEC[i]) begin
      int tgt = int'(VEC[i][31:24]);
      int rt  = int'(VEC[i][23:16]);
      int cv  = int'(VEC[i][15:8]);
      int w   = int'(VEC[i][7:0]);
      fire_on(tgt, rt, cv, w, i + 3);
      check("R2 strobes at note-on",
            int'({gate_we, sus_we, atk_we, dcy_we, rel_we}), 31);
      check("R2 attack nibble", int'(atk_nib), i + 3);
      check("R2 decay/release nibbles", int'({dcy_nib, rel_nib}), 0);
      for (int n = 0; n < 70; n++) begin
        if (n > 0) tick();
        check(cv != 0 ? "R7 sustain curve" : "R6 sustain linear",
              int'(sus_val), exp_sus(n, tgt, rt, cv, w));
        check("R3 gate", int'(gate), (n < 4) ? 0 : 1);
        if (n == 1)
          check("R2 strobes one cycle",
                int'({sus_we, atk_we, dcy_we, rel_we}), 0);
        if (n == 4) check("R3 gate strobe", int'(gate_we), 1);
      end
    end

    // R10: raise target during hold, sustain must stay
    fire_on(8, 2, 0, 2, 1);
    repeat (40) tick();
    check("R6 hold at target", int'(sus_val), 8);
    sus_target = 4'd13;
    repeat (10) tick();
    check("R10 no rise while gated", int'(sus_val), 8);
    check("R10 gate still high", int'(gate), 1);

    // R8: release from hold, rate 2
    sus_target = 4'd8;
    fire_off();
    tick();
    check("R8 release not early", int'(sus_val), 8);
    tick();
    check("R8 first release step", int'(sus_val), 7);
    check("R11 sustain strobe on step", int'(sus_we), 1);
    tick();
    check("R11 strobe one cycle", int'(sus_we), 0);
    repeat (13) tick();
    check("R8 release reaches zero", int'(sus_val), 0);
    repeat (6) tick();
    check("R8 stays zero", int'(sus_val), 0);
    check("R8 gate stays high", int'(gate), 1);

    // R9: note-off during attack wait
    fire_on(8, 2, 0, 10, 2);
    repeat (5) tick();
    fire_off();                    // n = 6
    repeat (8) tick();             // n = 14
    check("R9 held at 15 through attack", int'(sus_val), 15);
    repeat (2) tick();             // n = 16
    check("R9 release first step", int'(sus_val), 14);
    repeat (34) tick();            // n = 50
    check("R9 release past target to zero", int'(sus_val), 0);
    check("R9 gate high", int'(gate), 1);

    // R4: second note-on inside the gap
    fire_on(10, 3, 0, 4, 5);
    tick();                        // n = 1
    note_on = 1'b1;
    tick();                        // n = 2
    note_on = 1'b0;
    tick();                        // n = 3
    check("R4 gate low in gap", int'(gate), 0);
    tick();                        // n = 4
    check("R4 gap not extended", int'(gate), 1);
    repeat (7) tick();             // n = 11 = 4+4+3
    check("R4 first step on schedule", int'(sus_val), 14);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule